// File: doc/BRIEF.md
# DRAM refresh and init sequencer

This block owns the housekeeping of an asynchronous DRAM on behalf of a memory controller. Out of reset it waits out the supply-settling pause, then runs a fixed number of wake-up strobe cycles, and only then declares the memory ready for ordinary accesses. From that point on it counts refresh intervals and issues one CAS-before-RAS refresh per interval. Each refresh uses the device's internal row counter, so no address is produced and the data bus is never driven.

The strobes are shared with an access controller through an external arbiter. The sequencer raises `req_o` when it owes a cycle. It starts a cycle only in a clock where `grant_i` is high, and it keeps `req_o` asserted until precharge has ended. While the grant is withheld, owed refreshes pile up in a bounded backlog. When the backlog is full the sequencer raises an urgent flag. If one more interval passes after that, it reports an overflow and runs the wake-up cycles again, since the retention deadline may have been missed.

All durations are counted in clock cycles and set by parameters. The defaults assume a 20 ns clock: a 200 µs pause, eight wake-up cycles, and a refresh roughly every 15.6 µs, which gives 512 refreshes per 8 ms.

Top module: `dram_upkeep_seq`

## Requirements
- R1: While reset is asserted, and for at least PAUSE_CYC cycles after it is released, `req_o` and `busy_o` stay low, `init_done_o` stays low, and `ras_n_o` and every bit of `cas_n_o` stay high.
- R2: After the pause, exactly WAKE_CNT refresh cycles are issued, and then `init_done_o` rises.
- R3: A strobe cycle begins only in a clock where `grant_i` is high. While the grant is low, no cycle begins, whether the work owed is wake-up cycles or refreshes.
- R4: Each cycle drives all `cas_n_o` bits low CSR_CYC cycles before `ras_n_o` falls. CAS stays low for the whole RAS-low phase, and RAS is low for exactly RAS_CYC cycles.
- R5: After RAS rises, both strobes stay high for at least PRE_CYC cycles before the next CAS fall.
- R6: Once `init_done_o` is high, one refresh becomes owed every INTERVAL_CYC cycles. With the grant always present, consecutive RAS falls are INTERVAL_CYC cycles apart.
- R7: While the grant is withheld, owed refreshes accumulate. When the grant returns, exactly that many refresh cycles run back to back, and then `req_o` drops.
- R8: `urgent_o` is high exactly while the backlog holds BACKLOG_MAX owed refreshes.
- R9: If an interval expires while the backlog is already full and no cycle is completing, `err_o` pulses for one cycle. The backlog is then cleared, `init_done_o` falls, and WAKE_CNT wake-up cycles are issued again without a new pause.
- R10: `busy_o` is high throughout every strobe cycle, from the CAS fall to the end of precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grant_i | input | 1 | Arbiter grant of the DRAM strobes to this block |
| req_o | output | 1 | Request for the strobes, held until the cycle's precharge ends |
| urgent_o | output | 1 | Backlog is full |
| busy_o | output | 1 | A refresh or wake-up cycle is in progress |
| init_done_o | output | 1 | Pause and wake-up cycles are complete, so accesses may proceed |
| err_o | output | 1 | One-cycle pulse when the backlog overflows |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | CAS_LANES | Column strobes for every byte lane, active low, all driven together |

## Verification
The refresh scheduler is tested by withholding the grant for one, two, three, seven and eight intervals and then releasing it. The number of back-to-back cycles that follow shows whether every owed refresh was kept, and the urgent flag separates a full backlog from a nearly full one. A run with the grant always present shows the steady refresh spacing. A run held past the backlog limit must produce the error pulse, no cycles while still ungranted, and then exactly eight wake-up cycles with no fresh pause. A monitor checks the CAS-before-RAS ordering, the RAS-low length, the precharge gap and the grant condition on every cycle. A reset in the middle of a cycle shows that the strobes drop at once and that the pause starts over.

// File: rtl/dram_upkeep_pkg.sv
package dram_upkeep_pkg;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_CAS_LEAD = 2'd1,
    PH_RAS_LOW  = 2'd2,
    PH_PRECHG   = 2'd3
  } strobe_phase_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dram_upkeep_pause.sv
module dram_upkeep_pause
  import dram_upkeep_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);
  localparam int unsigned CW = cnt_width(PAUSE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      if (cnt_q == CW'(PAUSE_CYC - 1)) done_d = 1'b1;
      else                             cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R1: once the pause has ended it never ends again until reset
  assert_pause_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

endmodule

// File: rtl/dram_upkeep_ledger.sv
module dram_upkeep_ledger
  import dram_upkeep_pkg::*;
#(
  parameter int unsigned WAKE_CNT     = 8,
  parameter int unsigned INTERVAL_CYC = 780,
  parameter int unsigned BACKLOG_MAX  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_done_i,
  output logic pending_o,
  output logic init_done_o,
  output logic urgent_o,
  output logic ovf_o
);
  localparam int unsigned WW = cnt_width(WAKE_CNT);
  localparam int unsigned OW = cnt_width(BACKLOG_MAX);
  localparam int unsigned TW = cnt_width(INTERVAL_CYC);

  logic [WW-1:0] wake_q, wake_d;
  logic [OW-1:0] owed_q, owed_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          ready, tick, at_cap, ovf;

  always_comb begin
    ready  = (wake_q == '0);
    tick   = ready && (tmr_q == TW'(INTERVAL_CYC - 1));
    at_cap = (owed_q == OW'(BACKLOG_MAX));
    ovf    = tick && at_cap && !cyc_done_i;

    tmr_d  = (!ready || tick) ? '0 : tmr_q + 1'b1;
    wake_d = wake_q;
    owed_d = owed_q;
    if (ovf) begin
      wake_d = WW'(WAKE_CNT);
      owed_d = '0;
    end else begin
      if (cyc_done_i && !ready) wake_d = wake_q - 1'b1;
      if (tick && !(cyc_done_i && ready))      owed_d = owed_q + 1'b1;
      else if (!tick && cyc_done_i && ready)   owed_d = owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= WW'(WAKE_CNT);
      owed_q <= '0;
      tmr_q  <= '0;
    end else begin
      wake_q <= wake_d;
      owed_q <= owed_d;
      tmr_q  <= tmr_d;
    end
  end

  assign pending_o   = (wake_q != '0) || (owed_q != '0);
  assign init_done_o = ready;
  assign urgent_o    = at_cap;
  assign ovf_o       = ovf;

  // R8: backlog never exceeds its cap
  assert_backlog_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(BACKLOG_MAX));

  // R9: overflow reloads the wake-up count and clears the backlog
  assert_ovf_reinit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (wake_q == WW'(WAKE_CNT)) && (owed_q == '0) && !init_done_o);

  // R6: the ready phase starts with nothing owed
  assert_clean_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> (owed_q == '0));

endmodule

// File: rtl/dram_upkeep_strobe.sv
module dram_upkeep_strobe
  import dram_upkeep_pkg::*;
#(
  parameter int unsigned CSR_CYC = 1,
  parameter int unsigned RAS_CYC = 3,
  parameter int unsigned PRE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic grant_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned LONG_AB = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int unsigned LONGEST = (LONG_AB > PRE_CYC) ? LONG_AB : PRE_CYC;
  localparam int unsigned PW      = cnt_width(LONGEST);

  strobe_phase_t phase_q, phase_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          done;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (go_i && grant_i) begin
          phase_d = PH_CAS_LEAD;
          cnt_d   = '0;
        end
      end
      PH_CAS_LEAD: begin
        if (cnt_q == PW'(CSR_CYC - 1)) begin
          phase_d = PH_RAS_LOW;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      PH_RAS_LOW: begin
        if (cnt_q == PW'(RAS_CYC - 1)) begin
          phase_d = PH_PRECHG;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      PH_PRECHG: begin
        if (cnt_q == PW'(PRE_CYC - 1)) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
          done    = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cas_n_o = !((phase_q == PH_CAS_LEAD) || (phase_q == PH_RAS_LOW));
  assign ras_n_o = (phase_q != PH_RAS_LOW);
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done;

  // R4: RAS falls only with CAS already low in the previous cycle
  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  // R3: a cycle opens only after a clock with the grant present
  assert_start_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n_o) |-> $past(grant_i));

  // R5: RAS and CAS return high together to begin precharge
  assert_prechg_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> $rose(cas_n_o));

endmodule

// File: rtl/dram_upkeep_seq.sv
module dram_upkeep_seq
  import dram_upkeep_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 10000,
  parameter int unsigned WAKE_CNT     = 8,
  parameter int unsigned INTERVAL_CYC = 780,
  parameter int unsigned BACKLOG_MAX  = 8,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned RAS_CYC      = 3,
  parameter int unsigned PRE_CYC      = 2,
  parameter int unsigned CAS_LANES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grant_i,
  output logic                 req_o,
  output logic                 urgent_o,
  output logic                 busy_o,
  output logic                 init_done_o,
  output logic                 err_o,
  output logic                 ras_n_o,
  output logic [CAS_LANES-1:0] cas_n_o
);
  logic rst_meta_q, rst_sync_q;
  logic pause_done, pending, cyc_done, busy, cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dram_upkeep_pause #(.PAUSE_CYC(PAUSE_CYC)) u_pause (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .done_o (pause_done)
  );

  dram_upkeep_ledger #(
    .WAKE_CNT    (WAKE_CNT),
    .INTERVAL_CYC(INTERVAL_CYC),
    .BACKLOG_MAX (BACKLOG_MAX)
  ) u_ledger (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .cyc_done_i  (cyc_done),
    .pending_o   (pending),
    .init_done_o (init_done_o),
    .urgent_o    (urgent_o),
    .ovf_o       (err_o)
  );

  dram_upkeep_strobe #(
    .CSR_CYC(CSR_CYC),
    .RAS_CYC(RAS_CYC),
    .PRE_CYC(PRE_CYC)
  ) u_strobe (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .go_i    (pause_done && pending),
    .grant_i (grant_i),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n),
    .busy_o  (busy),
    .done_o  (cyc_done)
  );

  assign cas_n_o = {CAS_LANES{cas_n}};
  assign busy_o  = busy;
  assign req_o   = busy || (pause_done && pending);

  // R1: nothing is requested or strobed during the power-up pause
  assert_quiet_pause_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !pause_done |-> (!req_o && ras_n_o && (&cas_n_o)));

  // R8: a full backlog always keeps the request raised
  assert_urgent_requests_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    urgent_o |-> req_o);

  // R10: no strobe is active outside a busy cycle
  assert_busy_covers_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!ras_n_o || !cas_n) |-> busy_o);

endmodule

// File: tb/dram_upkeep_seq_test.sv
module dram_upkeep_seq_test;
  localparam int PAUSE = 20;
  localparam int WAKE  = 8;
  localparam int IVL   = 120;
  localparam int BMAX  = 8;
  localparam int CSR   = 1;
  localparam int RASC  = 3;
  localparam int PRE   = 2;
  localparam int LANES = 2;

  // hold intervals, expected drained cycles, expected urgent
  localparam int NVEC = 5;
  localparam int VEC [NVEC][3] = '{'{1, 1, 0}, '{3, 3, 0}, '{7, 7, 0},
                                   '{8, 8, 1}, '{2, 2, 0}};

  logic             clk = 1'b0;
  logic             rst_n;
  logic             grant_i;
  logic             req_o, urgent_o, busy_o, init_done_o, err_o, ras_n_o;
  logic [LANES-1:0] cas_n_o;

  int n_chk = 0;
  int n_fail = 0;
  int falls = 0;
  int errs = 0;
  int cyc = 0;
  int last_fall = 0;

  always #10 clk = ~clk;

  dram_upkeep_seq #(
    .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INTERVAL_CYC(IVL), .BACKLOG_MAX(BMAX),
    .CSR_CYC(CSR), .RAS_CYC(RASC), .PRE_CYC(PRE), .CAS_LANES(LANES)
  ) uut (
    .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .req_o(req_o),
    .urgent_o(urgent_o), .busy_o(busy_o), .init_done_o(init_done_o),
    .err_o(err_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // strobe monitor, sampled on the falling clock edge
  logic prev_ras = 1'b1;
  logic prev_cas = 1'b1;
  int   low_len = 0;
  int   hi_len = 0;
  bit   hi_valid = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_ras = 1'b1;
      prev_cas = 1'b1;
      low_len  = 0;
      hi_valid = 0;
    end else begin
      if (err_o) errs++;
      if (prev_cas && (cas_n_o == '0)) begin
        chk(grant_i, "R3 cycle opened without grant", int'(grant_i), 1);
        if (hi_valid) chk(hi_len >= PRE, "R5 precharge gap", hi_len, PRE);
        hi_valid = 0;
      end
      if (prev_ras && !ras_n_o) begin
        falls++;
        last_fall = cyc;
        chk((cas_n_o == '0) && !prev_cas, "R4 CAS low ahead of RAS", int'(cas_n_o), 0);
        chk(busy_o, "R10 busy during cycle", int'(busy_o), 1);
      end
      if (!ras_n_o) begin
        low_len++;
        if (cas_n_o != '0) chk(1'b0, "R4 CAS held through RAS low", int'(cas_n_o), 0);
      end
      if (!prev_ras && ras_n_o) begin
        chk(low_len == RASC, "R4 RAS low length", low_len, RASC);
        low_len  = 0;
        hi_len   = 0;
        hi_valid = 1;
      end else if (ras_n_o && (cas_n_o == '1)) hi_len++;
      prev_ras = ras_n_o;
      prev_cas = (cas_n_o != '0);
    end
  end

  task automatic wait_req(input logic val, input int limit, input string tag);
    int n = 0;
    while ((req_o !== val || (val == 1'b0 && busy_o)) && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(n < limit, tag, int'(req_o), int'(val));
  endtask

  task automatic wait_ready(input int limit, input string tag, output int took);
    took = 0;
    while (!init_done_o && took < limit) begin
      @(negedge clk);
      took++;
    end
    chk(took < limit, tag, int'(init_done_o), 1);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base, took, t1;
    rst_n   = 1'b0;
    grant_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(ras_n_o && (cas_n_o == '1), "R1 strobes idle in reset", int'(ras_n_o), 1);
    chk(!req_o && !busy_o && !init_done_o && !err_o, "R1 outputs low in reset",
        int'(req_o), 0);
    base = falls;
    #5 rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(!req_o && !init_done_o && ras_n_o, "R1 quiet during pause", int'(req_o), 0);
    wait_ready(300, "R2 init completes", took);
    chk(took + 12 >= PAUSE, "R1 pause length", took + 12, PAUSE);
    chk(falls - base == WAKE, "R2 wake-up count", falls - base, WAKE);

    // backlog vectors: R6, R7, R8
    for (int v = 0; v < NVEC; v++) begin
      wait_req(1'b0, 300, "R7 idle before vector");
      @(negedge clk); #5 grant_i = 1'b0;
      wait_req(1'b1, 2 * IVL, "R6 refresh owed after interval");
      repeat ((VEC[v][0] - 1) * IVL + IVL / 2) @(negedge clk);
      chk(int'(urgent_o) == VEC[v][2], "R8 urgent level", int'(urgent_o), VEC[v][2]);
      chk(!busy_o, "R3 no cycle while ungranted", int'(busy_o), 0);
      base = falls;
      #5 grant_i = 1'b1;
      @(negedge clk);
      wait_req(1'b0, 100, "R7 drain finishes");
      chk(falls - base == VEC[v][1], "R7 drained refreshes", falls - base, VEC[v][1]);
      chk(!urgent_o, "R8 urgent clears after drain", int'(urgent_o), 0);
    end

    // steady spacing with grant always present: R6
    base = falls;
    while (falls == base) @(negedge clk);
    t1 = last_fall;
    base = falls;
    while (falls == base) @(negedge clk);
    chk(last_fall - t1 == IVL, "R6 refresh spacing", last_fall - t1, IVL);

    // overflow and re-initialisation: R9
    wait_req(1'b0, 300, "R9 idle before overflow");
    @(negedge clk); #5 grant_i = 1'b0;
    wait_req(1'b1, 2 * IVL, "R9 first owed");
    base = errs;
    repeat (7 * IVL + IVL / 2) @(negedge clk);
    chk(urgent_o && init_done_o, "R8 full backlog urgent", int'(urgent_o), 1);
    chk(errs == base, "R9 no error at cap", errs - base, 0);
    repeat (IVL) @(negedge clk);
    chk(errs - base == 1, "R9 one error pulse", errs - base, 1);
    chk(!init_done_o && !urgent_o && req_o, "R9 re-init pending", int'(init_done_o), 0);
    base = falls;
    repeat (30) @(negedge clk);
    chk(falls == base, "R3 wake-up waits for grant", falls - base, 0);
    #5 grant_i = 1'b1;
    wait_ready(100, "R9 re-init completes", took);
    chk(falls - base == WAKE, "R9 wake-up repeated", falls - base, WAKE);
    chk(took <= WAKE * (CSR + RASC + PRE + 1) + 2, "R9 no second pause", took,
        WAKE * (CSR + RASC + PRE + 1));

    // reset in the middle of a cycle: R1
    while (!busy_o) @(negedge clk);
    #5 rst_n = 1'b0;
    @(negedge clk);
    chk(ras_n_o && (cas_n_o == '1) && !busy_o && !req_o, "R1 reset drops strobes",
        int'(busy_o), 0);
    #5 rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(!req_o && !init_done_o, "R1 pause restarts", int'(req_o), 0);
    wait_ready(300, "R2 init after second reset", took);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule